// File: doc/BRIEF.md
# Receive Error-Aware FIFO Filter

This block sits between a serial receiver and the software-visible receive queue. Every character arrives with three error tags: parity, framing and break. The block stores characters together with their tags in a 64-entry queue. It can discard errored characters before they are stored. It also reports how many clean characters can be read before the first errored one.

Software reads a length register to move a known run of clean bytes in one burst, then handles the errored entry by itself. The block also drives a line-status summary: an error-present flag and a sticky overrun flag. A prioritised interrupt identification code selects among line status, good-data-available, data-available and receive timeout.

Top module: `gdrx_filter`

## Requirements
- R1: After reset the queue is empty, `head_valid` is 0, `gdl_reg` reads 0x00, both line-status flags are 0, `iir_code` is 0x01 and `irq` is 0.
- R2: Characters leave the queue in arrival order. `head_note` carries the error tags of the head entry at fixed positions: bit0 parity, bit1 framing, bit4 break. Bit2 of `head_note` shows the overrun flag. All other bits are 0.
- R3: A character that arrives while 64 entries are held is discarded and sets `lsr_ovr`. `lsr_ovr` stays set until a cycle with `lsr_rd` high.
- R4: While `cfg_gd_only` is 1, a character with any error tag is discarded and the queue does not grow. Clean characters are still stored.
- R5: While `cfg_gd_en` is 1, `gdl_reg[6:0]` holds the number of clean entries ahead of the first errored entry, counted from the head. `gdl_reg[7]` is 1 when any errored entry is held. While `cfg_gd_en` is 0, `gdl_reg` reads 0x00.
- R6: Once an errored head entry is popped, the count resumes over the clean entries that follow it, up to the next errored entry.
- R7: `lsr_rxerr` is 1 exactly while at least one errored entry is held.
- R8: `iir_code` shows the highest pending source, in this priority order: line status 0x06, good data 0x1C, data available 0x04, timeout 0x0C. With no source pending it shows 0x01. `irq` is 1 whenever the code is not 0x01.
- R9: Data-available is pending while at least RX_TRIG (default 4) entries are held. A timeout is latched by an `rx_tmo` pulse while the queue is not empty, and a pop clears it.
- R10: `ie_lsi` gates the line-status source (an errored entry or overrun). `ie_gd` gates the good-data source (`cfg_gd_en` and a non-zero clean count). `ie_rda` gates both data-available and timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received character is presented this cycle |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error tag |
| rx_ferr | input | 1 | Framing error tag |
| rx_brk | input | 1 | Break tag |
| rx_tmo | input | 1 | Receiver idle-timeout pulse |
| cfg_gd_en | input | 1 | Good-data length reporting enable |
| cfg_gd_only | input | 1 | Discard errored characters |
| ie_lsi | input | 1 | Line-status interrupt enable |
| ie_gd | input | 1 | Good-data interrupt enable |
| ie_rda | input | 1 | Data-available and timeout interrupt enable |
| pop | input | 1 | Remove the head entry |
| head_valid | output | 1 | Queue not empty |
| head_data | output | 8 | Head character (0 when empty) |
| head_note | output | 8 | Head error tags plus overrun flag |
| gdl_reg | output | 8 | Bad-present flag in bit 7, clean count in bits 6:0 |
| lsr_rxerr | output | 1 | Errored entry present in queue |
| lsr_ovr | output | 1 | Sticky overrun flag |
| lsr_rd | input | 1 | Line-status read; clears overrun |
| iir_code | output | 8 | Interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
The clean count is rebuilt each cycle from the stored tags. A corrupted tag or pointer therefore appears in `gdl_reg` and `lsr_rxerr` in the same cycle, and a pointer slip also shows a wrong `head_data` at the next pop. Count-tracking faults show up in the first 64-entry fill: the overrun must appear on exactly the 65th arrival, and the last drained byte must be the 64th. A latched timeout or overrun that fails to clear keeps `iir_code` away from 0x01 after the clearing event.

// File: rtl/gdrx_pkg.sv
// Shared types and interrupt codes for the error-aware receive filter.
package gdrx_pkg;
    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_ent_t;

    localparam logic [7:0] IIR_NONE = 8'h01;
    localparam logic [7:0] IIR_LSI  = 8'h06;
    localparam logic [7:0] IIR_GD   = 8'h1C;
    localparam logic [7:0] IIR_RDA  = 8'h04;
    localparam logic [7:0] IIR_RTO  = 8'h0C;
endpackage

// File: rtl/gdrx_store.sv
// Circular entry store with occupancy count.
// Assumes DEPTH is a power of two. A push while full is refused; the caller
// sees this through push_lost. Exposes per-slot error flags for the run scan.
module gdrx_store
    import gdrx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  rx_ent_t          push_ent,
    input  logic             pop_req,
    output rx_ent_t          head_ent,
    output logic [PW-1:0]    rd_ptr,
    output logic [CW-1:0]    cnt,
    output logic [DEPTH-1:0] errv,
    output logic             push_lost,
    output logic             pop_fire
);
    rx_ent_t       mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic          full, push_fire;

    assign full      = (cnt == CW'(DEPTH));
    assign push_fire = push_req && !full;
    assign push_lost = push_req && full;
    assign pop_fire  = pop_req && (cnt != '0);
    assign head_ent  = mem[rd_ptr];

    // Per-slot error summary for the scanner.
    for (genvar g = 0; g < DEPTH; g++) begin : g_err
        assign errv[g] = mem[g].perr | mem[g].ferr | mem[g].brk;
    end

    // Write the arriving entry into its slot.
    always_ff @(posedge clk) begin
        if (push_fire) mem[wr_ptr] <= push_ent;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_fire) wr_ptr <= wr_ptr + 1'b1;
            if (pop_fire)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + CW'(push_fire) - CW'(pop_fire);
        end
    end

    // R3: a refused push leaves occupancy untouched
    p_full_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop_req) |=> (cnt == CW'(DEPTH)));
    // R2: occupancy never exceeds capacity
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
endmodule

// File: rtl/gdrx_runscan.sv
// Counts clean entries from the head up to the first errored entry, and
// flags whether any held entry is errored. Purely combinational.
module gdrx_runscan #(
    parameter int DEPTH = 64,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0] errv,
    input  logic [PW-1:0]    rd_ptr,
    input  logic [CW-1:0]    cnt,
    output logic [CW-1:0]    run,
    output logic             bad_any
);
    logic [PW-1:0] idx;
    logic          stop;

    // Walk held slots from the head, stopping the count at the first error.
    always_comb begin
        run     = '0;
        bad_any = 1'b0;
        stop    = 1'b0;
        idx     = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx = rd_ptr + PW'(i);
            if (CW'(i) < cnt) begin
                if (errv[idx]) begin
                    stop    = 1'b1;
                    bad_any = 1'b1;
                end else if (!stop) begin
                    run = run + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/gdrx_irq.sv
// Fixed-priority interrupt identification: line status, good data,
// data available, timeout. Combinational.
module gdrx_irq
    import gdrx_pkg::*;
(
    input  logic       lsi_pend,
    input  logic       gd_pend,
    input  logic       rda_pend,
    input  logic       rto_pend,
    output logic [7:0] code,
    output logic       req
);
    // Select the highest pending source.
    always_comb begin
        if (lsi_pend)      code = IIR_LSI;
        else if (gd_pend)  code = IIR_GD;
        else if (rda_pend) code = IIR_RDA;
        else if (rto_pend) code = IIR_RTO;
        else               code = IIR_NONE;
    end

    assign req = lsi_pend | gd_pend | rda_pend | rto_pend;
endmodule

// File: rtl/gdrx_filter.sv
// Error-aware receive filter: optional discard of errored characters,
// clean-run length report, line-status summary and interrupt coding.
// Assumes one character per cycle at most; rx_tmo is a single-cycle pulse.
module gdrx_filter
    import gdrx_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int RX_TRIG = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  logic       rx_brk,
    input  logic       rx_tmo,
    input  logic       cfg_gd_en,
    input  logic       cfg_gd_only,
    input  logic       ie_lsi,
    input  logic       ie_gd,
    input  logic       ie_rda,
    input  logic       pop,
    output logic       head_valid,
    output logic [7:0] head_data,
    output logic [7:0] head_note,
    output logic [7:0] gdl_reg,
    output logic       lsr_rxerr,
    output logic       lsr_ovr,
    input  logic       lsr_rd,
    output logic [7:0] iir_code,
    output logic       irq
);
    rx_ent_t          in_ent, head_ent;
    logic             in_bad, push_req, push_lost, pop_fire;
    logic [PW-1:0]    rd_ptr;
    logic [CW-1:0]    cnt, run;
    logic [DEPTH-1:0] errv;
    logic             bad_any, rto_flag;

    assign in_ent   = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};
    assign in_bad   = rx_perr | rx_ferr | rx_brk;
    assign push_req = rx_valid && !(cfg_gd_only && in_bad);

    gdrx_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_ent(in_ent),
        .pop_req(pop), .head_ent(head_ent), .rd_ptr(rd_ptr), .cnt(cnt),
        .errv(errv), .push_lost(push_lost), .pop_fire(pop_fire)
    );

    gdrx_runscan #(.DEPTH(DEPTH)) u_scan (
        .errv(errv), .rd_ptr(rd_ptr), .cnt(cnt), .run(run), .bad_any(bad_any)
    );

    // Sticky overrun: set on a refused push, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)         lsr_ovr <= 1'b0;
        else if (push_lost) lsr_ovr <= 1'b1;
        else if (lsr_rd)    lsr_ovr <= 1'b0;
    end

    // Timeout latch: armed by an idle pulse with data held, cleared by a pop.
    always_ff @(posedge clk) begin
        if (!rst_n)                      rto_flag <= 1'b0;
        else if (pop_fire)               rto_flag <= 1'b0;
        else if (rx_tmo && cnt != '0)    rto_flag <= 1'b1;
    end

    assign head_valid = (cnt != '0);
    assign head_data  = head_valid ? head_ent.data : 8'h00;
    assign head_note  = {3'b000, head_valid & head_ent.brk, 1'b0, lsr_ovr,
                         head_valid & head_ent.ferr, head_valid & head_ent.perr};
    assign gdl_reg    = cfg_gd_en ? {bad_any, 7'(run)} : 8'h00;
    assign lsr_rxerr  = bad_any;

    gdrx_irq u_irq (
        .lsi_pend(ie_lsi && (bad_any || lsr_ovr)),
        .gd_pend (ie_gd && cfg_gd_en && run != '0),
        .rda_pend(ie_rda && cnt >= CW'(RX_TRIG)),
        .rto_pend(ie_rda && rto_flag),
        .code(iir_code), .req(irq)
    );

    // R4: an errored arrival in discard mode never grows the queue
    p_drop_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_gd_only && in_bad && !pop) |=> (cnt == $past(cnt)));
    // R3: overrun persists until a status read
    p_ovr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_ovr && !lsr_rd) |=> lsr_ovr);
    // R5: the clean run never exceeds occupancy, and is short of it when an error is held
    p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run <= cnt) && (!bad_any || run < cnt));
    // R9: a pop always clears the latched timeout
    p_rto_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_fire |=> !rto_flag);
    // R8: an enabled line-status condition always wins the code
    p_lsi_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_lsi && (lsr_rxerr || lsr_ovr)) |-> (iir_code == IIR_LSI && irq));
endmodule

// File: tb/gdrx_filter_bench.sv
module gdrx_filter_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0, rx_tmo = 0;
    logic [7:0] rx_data = 0;
    logic cfg_gd_en = 0, cfg_gd_only = 0, ie_lsi = 0, ie_gd = 0, ie_rda = 0;
    logic pop = 0, lsr_rd = 0;
    logic head_valid, lsr_rxerr, lsr_ovr, irq;
    logic [7:0] head_data, head_note, gdl_reg, iir_code;
    int n_run = 0, n_fail = 0, cyc = 0;

    gdrx_filter u_gdrx_filter (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
        rx_valid = 1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
        tick();
        rx_valid = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
    endtask

    task automatic do_pop();
        pop = 1; tick(); pop = 0;
    endtask

    task automatic t_reset();
        chk("R1 head_valid", head_valid, 0);
        chk("R1 gdl", gdl_reg, 8'h00);
        chk("R1 lsr", {lsr_rxerr, lsr_ovr}, 0);
        chk("R1 iir", iir_code, 8'h01);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_order();
        cfg_gd_en = 1;
        push(8'hA1, 0, 0, 0);
        push(8'hB2, 1, 0, 0);
        push(8'hC3, 0, 0, 0);
        push(8'hD4, 0, 1, 1);
        chk("R5 gdl run1 bad", gdl_reg, 8'h81);
        chk("R7 rxerr held", lsr_rxerr, 1);
        chk("R2 head A", head_data, 8'hA1);
        chk("R2 note A", head_note, 8'h00);
        do_pop();
        chk("R5 gdl errored head", gdl_reg, 8'h80);
        chk("R2 head B", head_data, 8'hB2);
        chk("R2 note B parity", head_note, 8'h01);
        do_pop();
        chk("R6 gdl resumes", gdl_reg, 8'h81);
        chk("R2 head C", head_data, 8'hC3);
        do_pop();
        chk("R2 note D framing+break", head_note, 8'h12);
        do_pop();
        chk("R7 rxerr cleared", lsr_rxerr, 0);
        chk("R5 gdl empty", gdl_reg, 8'h00);
        cfg_gd_en = 0;
        push(8'h55, 0, 0, 0);
        chk("R5 gdl disabled", gdl_reg, 8'h00);
        do_pop();
    endtask

    task automatic t_gd_only();
        cfg_gd_only = 1;
        push(8'hE0, 0, 1, 0);
        chk("R4 errored dropped", head_valid, 0);
        push(8'h3C, 0, 0, 0);
        chk("R4 clean kept", head_data, 8'h3C);
        do_pop();
        chk("R4 single entry", head_valid, 0);
        cfg_gd_only = 0;
    endtask

    task automatic t_irq();
        ie_lsi = 1; ie_gd = 1; ie_rda = 1; cfg_gd_en = 1;
        chk("R8 idle code", iir_code, 8'h01);
        push(8'h10, 0, 0, 0);
        chk("R8 good-data code", iir_code, 8'h1C);
        cfg_gd_en = 0; #1;
        chk("R9 below trigger", iir_code, 8'h01);
        chk("R8 irq low", irq, 0);
        rx_tmo = 1; tick(); rx_tmo = 0;
        chk("R9 timeout code", iir_code, 8'h0C);
        do_pop();
        chk("R9 timeout cleared", iir_code, 8'h01);
        for (int i = 0; i < 4; i++) push(8'(8'h20 + i), 0, 0, 0);
        chk("R9 trigger code", iir_code, 8'h04);
        push(8'h99, 0, 0, 1);
        chk("R8 line status wins", iir_code, 8'h06);
        ie_lsi = 0; #1;
        chk("R10 lsi gated", iir_code, 8'h04);
        cfg_gd_en = 1; #1;
        chk("R8 gd over rda", iir_code, 8'h1C);
        ie_gd = 0; ie_rda = 0; #1;
        chk("R10 all gated", irq, 0);
        for (int i = 0; i < 5; i++) do_pop();
        cfg_gd_en = 0;
    endtask

    task automatic t_full();
        for (int i = 0; i < 64; i++) push(8'(i), 0, 0, 0);
        chk("R3 no overrun at 64", lsr_ovr, 0);
        push(8'hFF, 0, 0, 0);
        chk("R3 overrun set", lsr_ovr, 1);
        chk("R2 overrun note bit", head_note, 8'h04);
        for (int i = 0; i < 63; i++) do_pop();
        chk("R3 last kept entry", head_data, 8'd63);
        do_pop();
        chk("R3 drained", head_valid, 0);
        chk("R3 overrun sticky", lsr_ovr, 1);
        ie_lsi = 1; #1;
        chk("R10 overrun line status", iir_code, 8'h06);
        lsr_rd = 1; tick(); lsr_rd = 0;
        chk("R3 overrun cleared", lsr_ovr, 0);
        chk("R8 idle after clear", iir_code, 8'h01);
        ie_lsi = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        t_reset();
        t_order();
        t_gd_only();
        t_irq();
        t_full();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule